// File: doc/BRIEF.md
# Sorting Front End with Duplicate-Destination Trap

This block prepares one column of fixed-size cells for a self-routing binary fabric, so that the fabric does not block internally. Each clock cycle it accepts a set of slots. Every slot carries a valid flag and a destination tag. The block orders the valid cells by destination using a pipelined odd-even merge sorting network of compare-exchange elements, with one register after each comparator column. Empty slots rank above every real destination, so they settle at the high end.

After the sorting network, a trap stage looks at neighbouring sorted cells. When two share a destination, the lower-position cell continues and the later copy is pulled out. The pulled-out copy is reported on a separate set of trapped-cell outputs, which a recirculation path elsewhere can pick up. The surviving cells are packed into the lowest positions with no holes. They then pass through a perfect-shuffle permutation and leave through an output register.

A new set of slots can be presented on every cycle. The result of each set emerges a fixed number of cycles later.

Top module: `bsd_top`

## Requirements
- R1: Latency is fixed. A set of slots sampled at one rising edge appears at the outputs just after the S+1-th rising edge that follows, where S = log2(SLOTS)*(log2(SLOTS)+1)/2 (7 edges for 8 slots). A new set is accepted at every edge.
- R2: The surviving cells, taken in pre-shuffle position order, have strictly ascending destination tags.
- R3: An empty input slot ranks above every valid tag, whatever its tag input holds. Every output slot and trapped slot that is not valid shows tag 0.
- R4: Of all cells in one set that share a destination, exactly one reaches the main outputs. Every other copy is reported as trapped.
- R5: Trapped slot i is valid exactly when sorted position i holds a valid cell whose tag equals that of sorted position i-1, and it then carries that tag. Sorted position 0 is never trapped.
- R6: Before the shuffle, the K surviving cells (K = number of distinct destinations) occupy positions 0 to K-1 with no gap.
- R7: The shuffle moves pre-shuffle position p to output position 2p when p < SLOTS/2, and to 2p-SLOTS+1 otherwise. This is a one-bit left rotation of the index.
- R8: While reset is asserted, all output and trapped valid flags and tags are 0, whatever the inputs are.
- R9: For every set, the number of valid main outputs plus the number of valid trapped outputs equals the number of valid input slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | SLOTS | Valid flag per input slot |
| in_tag | input | SLOTS*TAG_W | Destination tag per slot; slot i at bits i*TAG_W upward |
| out_vld | output | SLOTS | Valid flag per shuffled output slot |
| out_tag | output | SLOTS*TAG_W | Destination tag per shuffled output slot |
| trap_vld | output | SLOTS | Trapped flag per sorted position |
| trap_tag | output | SLOTS*TAG_W | Tag of the trapped copy per sorted position |

## Verification
Several patterns are used, each to separate a different kind of fault:
- Two fixed sets with known answers. One is a full set with two repeated destinations; the other is sparse with one repeated destination among empty slots. Together they separate comparator-wiring errors from trap and shuffle errors.
- All slots on one destination, which stresses the trap stage.
- All slots distinct in reverse order, which needs every comparator to swap.
- A fully empty set, and empty slots carrying non-zero tags, which expose mistakes in how idle slots are ranked.
- A long stream of pseudo-random sets, one per cycle. This checks that neighbouring sets in the pipeline do not mix, and it checks the latency count.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

  // Number of comparator columns of the odd-even merge sorter.
  function automatic int sort_stages(int lg);
    return lg * (lg + 1) / 2;
  endfunction

  // Merge level (log2 of sorted run length) used by column s.
  function automatic int stage_pl(int s, int lg);
    int c;
    c = 0;
    for (int pl = 0; pl < lg; pl++)
      for (int kl = pl; kl >= 0; kl--) begin
        if (c == s) return pl;
        c++;
      end
    return 0;
  endfunction

  // Log2 of the compare distance used by column s.
  function automatic int stage_kl(int s, int lg);
    int c;
    c = 0;
    for (int pl = 0; pl < lg; pl++)
      for (int kl = pl; kl >= 0; kl--) begin
        if (c == s) return kl;
        c++;
      end
    return 0;
  endfunction

  // Role of position x in a column with run length p and distance k:
  // 1 = lower input of a comparator, 2 = upper input, 0 = wire through.
  function automatic int cx_role(int x, int p, int k, int n);
    int j0;
    j0 = k % p;
    if (x >= j0 && ((x - j0) % (2 * k)) < k && x + k < n &&
        (x / (2 * p)) == ((x + k) / (2 * p)))
      return 1;
    if (x - k >= j0 && ((x - k - j0) % (2 * k)) < k &&
        ((x - k) / (2 * p)) == (x / (2 * p)))
      return 2;
    return 0;
  endfunction

  // Perfect shuffle: destination index of position p among n slots.
  function automatic int shuffle_dst(int p, int n);
    return (p < n / 2) ? 2 * p : 2 * p - n + 1;
  endfunction

endpackage

// File: rtl/cmp_xchg.sv
module cmp_xchg #(
  parameter int W = 3
) (
  input  logic         a_v,
  input  logic [W-1:0] a_t,
  input  logic         b_v,
  input  logic [W-1:0] b_t,
  output logic         lo_v,
  output logic [W-1:0] lo_t,
  output logic         hi_v,
  output logic [W-1:0] hi_t
);
  // Ordering key: an idle cell ranks above every valid tag.
  logic swap;
  assign swap = {~a_v, a_t} > {~b_v, b_t};

  assign lo_v = swap ? b_v : a_v;
  assign lo_t = swap ? b_t : a_t;
  assign hi_v = swap ? a_v : b_v;
  assign hi_t = swap ? a_t : b_t;
endmodule

// File: rtl/sort_net.sv
module sort_net
  import bsd_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   in_v,
  input  logic [N*W-1:0] in_t,
  output logic [N-1:0]   out_v,
  output logic [N*W-1:0] out_t
);
  localparam int LG = $clog2(N);
  localparam int S  = sort_stages(LG);

  // Idle slots enter with tag 0 so their order is fully defined.
  logic [N*W-1:0] in_m;
  for (genvar i = 0; i < N; i++) begin : g_mask
    assign in_m[i*W +: W] = in_v[i] ? in_t[i*W +: W] : '0;
  end

  for (genvar s = 0; s < S; s++) begin : stg
    localparam int P = 1 << stage_pl(s, LG);
    localparam int K = 1 << stage_kl(s, LG);
    logic [N-1:0]   iv, nv, rv;
    logic [N*W-1:0] it, nt, rt;

    if (s == 0) begin : g_first
      assign iv = in_v;
      assign it = in_m;
    end else begin : g_next
      assign iv = stg[s-1].rv;
      assign it = stg[s-1].rt;
    end

    for (genvar x = 0; x < N; x++) begin : slot
      localparam int R = cx_role(x, P, K, N);
      if (R == 1) begin : g_cx
        cmp_xchg #(.W(W)) u_cx (
          .a_v (iv[x]),     .a_t (it[x*W +: W]),
          .b_v (iv[x+K]),   .b_t (it[(x+K)*W +: W]),
          .lo_v(nv[x]),     .lo_t(nt[x*W +: W]),
          .hi_v(nv[x+K]),   .hi_t(nt[(x+K)*W +: W])
        );
      end else if (R == 0) begin : g_pass
        assign nv[x]        = iv[x];
        assign nt[x*W +: W] = it[x*W +: W];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rv <= '0;
        rt <= '0;
      end else begin
        rv <= nv;
        rt <= nt;
      end
    end

    // Valid cells are neither created nor lost by a comparator column.
    if (s > 0) begin : g_chk
      assert_vld_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rv) == $past($countones(stg[s-1].rv)));
    end
  end

  assign out_v = stg[S-1].rv;
  assign out_t = stg[S-1].rt;

  for (genvar i = 1; i < N; i++) begin : g_ord
    assert_sorted_R2: assert property (@(posedge clk) disable iff (!rst_n)
      {~out_v[i-1], out_t[(i-1)*W +: W]} <= {~out_v[i], out_t[i*W +: W]});
  end
  for (genvar i = 0; i < N; i++) begin : g_idle
    assert_idle_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !out_v[i] |-> out_t[i*W +: W] == '0);
  end
endmodule

// File: rtl/trap_shuffle.sv
module trap_shuffle
  import bsd_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   s_v,
  input  logic [N*W-1:0] s_t,
  output logic [N-1:0]   o_v,
  output logic [N*W-1:0] o_t,
  output logic [N-1:0]   tr_v,
  output logic [N*W-1:0] tr_t
);
  localparam int IW = $clog2(N);

  // Named events: duplicate flags, survivors, compacted and shuffled buses.
  logic [N-1:0]   dup, keep, cmp_v, shf_v;
  logic [N*W-1:0] cmp_t, shf_t, trp_t;
  logic [IW:0]    rank [N];

  for (genvar i = 0; i < N; i++) begin : g_dup
    if (i == 0) begin : g_lo
      assign dup[i] = 1'b0;
    end else begin : g_hi
      assign dup[i] = s_v[i] && s_v[i-1] &&
                      (s_t[i*W +: W] == s_t[(i-1)*W +: W]);
    end
    assign keep[i]        = s_v[i] && !dup[i];
    assign trp_t[i*W +: W] = dup[i] ? s_t[i*W +: W] : '0;
  end

  // Rank of each survivor = number of survivors below it.
  always_comb begin
    logic [IW:0] acc;
    acc = '0;
    for (int i = 0; i < N; i++) begin
      rank[i] = acc;
      acc     = acc + {{IW{1'b0}}, keep[i]};
    end
  end

  always_comb begin
    cmp_v = '0;
    cmp_t = '0;
    for (int o = 0; o < N; o++)
      for (int i = 0; i < N; i++)
        if (keep[i] && rank[i] == (IW+1)'(o)) begin
          cmp_v[o]        = 1'b1;
          cmp_t[o*W +: W] = s_t[i*W +: W];
        end
  end

  for (genvar p = 0; p < N; p++) begin : g_shf
    localparam int D = shuffle_dst(p, N);
    assign shf_v[D]        = cmp_v[p];
    assign shf_t[D*W +: W] = cmp_t[p*W +: W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_v  <= '0;
      o_t  <= '0;
      tr_v <= '0;
      tr_t <= '0;
    end else begin
      o_v  <= shf_v;
      o_t  <= shf_t;
      tr_v <= dup;
      tr_t <= trp_t;
    end
  end

  assert_no_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_v & (cmp_v + 1'b1)) == '0);

  for (genvar i = 1; i < N; i++) begin : g_uniq
    assert_unique_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_v[i] |-> cmp_t[i*W +: W] > cmp_t[(i-1)*W +: W]);
  end

  assert_conserve_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(o_v) + $countones(tr_v) == $past($countones(s_v)));
endmodule

// File: rtl/bsd_top.sv
module bsd_top #(
  parameter int SLOTS = 8,
  parameter int TAG_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SLOTS-1:0]       in_vld,
  input  logic [SLOTS*TAG_W-1:0] in_tag,
  output logic [SLOTS-1:0]       out_vld,
  output logic [SLOTS*TAG_W-1:0] out_tag,
  output logic [SLOTS-1:0]       trap_vld,
  output logic [SLOTS*TAG_W-1:0] trap_tag
);
  logic [SLOTS-1:0]       srt_v;
  logic [SLOTS*TAG_W-1:0] srt_t;

  sort_net #(.N(SLOTS), .W(TAG_W)) u_sort (
    .clk  (clk),
    .rst_n(rst_n),
    .in_v (in_vld),
    .in_t (in_tag),
    .out_v(srt_v),
    .out_t(srt_t)
  );

  trap_shuffle #(.N(SLOTS), .W(TAG_W)) u_trap (
    .clk  (clk),
    .rst_n(rst_n),
    .s_v  (srt_v),
    .s_t  (srt_t),
    .o_v  (out_vld),
    .o_t  (out_tag),
    .tr_v (trap_vld),
    .tr_t (trap_tag)
  );

  // Sorted position 0 never holds a repeat.
  assert_first_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_vld[0]);
  // Any trapped copy implies at least one survivor in the same set.
  assert_survivor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|trap_vld) |-> out_vld[0]);
endmodule

// File: tb/bsd_top_test.sv
`timescale 1ns/1ps
module bsd_top_test;
  localparam int N   = 8;
  localparam int W   = 3;
  localparam int LG  = $clog2(N);
  localparam int LAT = LG * (LG + 1) / 2 + 1;
  localparam int M   = 150;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   in_vld = '0;
  logic [N*W-1:0] in_tag = '0;
  logic [N-1:0]   out_vld, trap_vld;
  logic [N*W-1:0] out_tag, trap_tag;

  int nvec = 0, nchk = 0, nfail = 0;
  bit done = 0;

  logic [N-1:0]   sv [M];
  logic [N*W-1:0] st [M];

  bsd_top #(.SLOTS(N), .TAG_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_tag(in_tag),
    .out_vld(out_vld), .out_tag(out_tag), .trap_vld(trap_vld), .trap_tag(trap_tag)
  );

  always #2.5 clk = ~clk;

  // Behavioural reference: plain sort, repeat marking, packing, shuffle.
  function automatic void model(input logic [N-1:0] v, input logic [N*W-1:0] t,
                                output logic [N-1:0] ov, output logic [N*W-1:0] ot,
                                output logic [N-1:0] tv, output logic [N*W-1:0] tt);
    int a[N];
    int c[N];
    int n, k, tmp, d;
    n = 0;
    for (int i = 0; i < N; i++)
      if (v[i]) begin a[n] = int'(t[i*W +: W]); n++; end
    for (int i = 0; i < n; i++)
      for (int j = 0; j < n - 1 - i; j++)
        if (a[j] > a[j+1]) begin tmp = a[j]; a[j] = a[j+1]; a[j+1] = tmp; end
    ov = '0; ot = '0; tv = '0; tt = '0; k = 0;
    for (int i = 0; i < n; i++)
      if (i > 0 && a[i] == a[i-1]) begin
        tv[i] = 1'b1; tt[i*W +: W] = W'(a[i]);
      end else begin
        c[k] = a[i]; k++;
      end
    for (int p = 0; p < k; p++) begin
      d = (p < N/2) ? 2*p : 2*p - N + 1;
      ov[d] = 1'b1; ot[d*W +: W] = W'(c[p]);
    end
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_set(logic [N-1:0] v, logic [N*W-1:0] t);
    logic [N-1:0] ev, etv;
    logic [N*W-1:0] et, ett;
    model(v, t, ev, et, etv, ett);
    nvec++;
    check("R2 R3 R6 R7 out_vld", 64'(out_vld), 64'(ev));
    check("R2 R3 R6 R7 out_tag", 64'(out_tag), 64'(et));
    check("R4 R5 trap_vld", 64'(trap_vld), 64'(etv));
    check("R3 R5 trap_tag", 64'(trap_tag), 64'(ett));
    check("R9 count", 64'($countones(out_vld) + $countones(trap_vld)), 64'($countones(v)));
  endtask

  task automatic run_hold(logic [N-1:0] v, logic [N*W-1:0] t);
    @(negedge clk);
    in_vld = v; in_tag = t;
    repeat (LAT) @(posedge clk);
    @(negedge clk);
    check_set(v, t);
  endtask

  function automatic logic [N*W-1:0] pack(int t0, int t1, int t2, int t3,
                                          int t4, int t5, int t6, int t7);
    return {W'(t7), W'(t6), W'(t5), W'(t4), W'(t3), W'(t2), W'(t1), W'(t0)};
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; in_vld = '1; in_tag = pack(1,2,3,4,5,6,7,1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 out_vld in reset", 64'(out_vld), 64'd0);
    check("R8 out_tag in reset", 64'(out_tag), 64'd0);
    check("R8 trap in reset", 64'({trap_vld, trap_tag}), 64'd0);
    in_vld = '0; in_tag = '0;
    rst_n = 1'b1;
  endtask

  task automatic t_listed_numbers();
    // 5,7,2,3,6,2,4,5 sorts to 2,2,3,4,5,5,6,7: copies at sorted 1 and 5.
    run_hold('1, pack(5,7,2,3,6,2,4,5));
    check("R5 trap positions", 64'(trap_vld), 64'(8'b0010_0010));
    check("R7 out slot2 (pre 1) tag 3", 64'(out_tag[2*W +: W]), 64'd3);
  endtask

  task automatic t_sparse_example();
    // X,011,010,X,011,X,X,X -> 010,X,011,X,X,X,X,X after trap and shuffle.
    run_hold(8'b0001_0110, pack(0,3,2,0,3,0,0,0));
    check("R7 sparse out_vld", 64'(out_vld), 64'(8'b0000_0101));
    check("R7 sparse slot0", 64'(out_tag[0 +: W]), 64'd2);
    check("R7 sparse slot2", 64'(out_tag[2*W +: W]), 64'd3);
    check("R4 sparse trapped slot2", 64'({trap_vld, trap_tag[2*W +: W]}), 64'({8'b0000_0100, 3'd3}));
  endtask

  task automatic t_all_same();
    run_hold('1, pack(5,5,5,5,5,5,5,5));
    check("R4 single survivor", 64'(out_vld), 64'd1);
  endtask

  task automatic t_reverse();
    run_hold('1, pack(7,6,5,4,3,2,1,0));
  endtask

  task automatic t_idle_garbage();
    // Empty slots carry non-zero tags; they must not rank or show up.
    run_hold(8'b1000_0001, pack(6,7,7,7,7,7,7,1));
    check("R3 idle tags hidden", 64'(out_tag), 64'(pack(1,0,6,0,0,0,0,0)));
    run_hold('0, '1);
    check("R3 empty set", 64'({out_vld, out_tag}), 64'd0);
  endtask

  task automatic t_latency();
    run_hold('0, '0);
    @(negedge clk);
    in_vld = 8'b0000_0011; in_tag = pack(4,1,0,0,0,0,0,0);
    repeat (LAT - 1) @(posedge clk);
    @(negedge clk);
    check("R1 not yet visible", 64'(out_vld), 64'd0);
    @(posedge clk);
    @(negedge clk);
    check_set(8'b0000_0011, pack(4,1,0,0,0,0,0,0));
  endtask

  task automatic t_stream();
    logic [31:0] s;
    s = 32'h1234_5678;
    for (int m = 0; m < M; m++) begin
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      sv[m] = s[N-1:0] | s[2*N-1:N];
      st[m] = s[31:32-N*W];
    end
    for (int c = 0; c < M + LAT; c++) begin
      @(negedge clk);
      if (c >= LAT) check_set(sv[c-LAT], st[c-LAT]);   // R1 back-to-back
      if (c < M) begin in_vld = sv[c]; in_tag = st[c]; end
      else begin in_vld = '0; in_tag = '0; end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    nfail++;
    $display("FAIL watchdog expired (R1 progress) actual=hung expected=done");
    finish_run();
  end

  initial begin
    t_reset();
    t_listed_numbers();
    t_sparse_example();
    t_all_same();
    t_reverse();
    t_idle_garbage();
    t_latency();
    t_stream();
    finish_run();
  end
endmodule